// File: doc/BRIEF.md
# Multidrop Serial Receiver with Ninth-Bit Address Filtering

This block receives asynchronous serial frames (one start bit, eight or nine data bits sent least significant bit first, one stop bit) and places each accepted frame into a single-entry holding register. It is meant for a slave node on a shared multidrop line, where one master talks to many receivers. Each frame's ninth bit marks it as either an address (1) or data (0).

With nine-bit mode and address filtering both on, the receiver accepts only address frames. Data frames are thrown away after their stop bit, so the host is woken only when an address arrives. Once the host sees its own address, it turns filtering off and then receives every frame. In that state the ninth bit is passed through untouched, and the host may use it as a parity bit. The line is sampled from a free-running oversampling tick supplied by an external baud generator. A frame's mode settings are captured when its start bit is confirmed.

Top module: `mdrop_uart_rx`

## Requirements
- R1: After reset, rx_ready, rx_irq, frame_err, overrun_err and rx_bit9 are 0 and rx_data is 0x00.
- R2: In eight-bit mode (nine_bit_en=0), a frame with bits sent LSB first is delivered. rx_data holds the byte, rx_bit9 reads 0 and rx_ready is set before the stop bit ends.
- R3: In nine-bit mode, the ninth received bit (sent after data bit 7) appears on rx_bit9 alongside rx_data.
- R4: With nine_bit_en=1 and addr_det_en=1, a frame whose ninth bit is 1 is delivered. A frame whose ninth bit is 0 is dropped: rx_ready stays 0, rx_irq stays 0, and rx_data and rx_bit9 keep their previous values.
- R5: In eight-bit mode, addr_det_en has no effect and every frame is delivered.
- R6: In nine-bit mode with addr_det_en=0, every frame is delivered, whatever its ninth bit.
- R7: While rx_en=0, no frame is received. One cycle with rx_en=0 clears frame_err and overrun_err.
- R8: A stop bit sampled low on a delivered frame sets frame_err. The frame's data is still delivered.
- R9: rx_irq is 1 exactly when rx_ready is 1 and rx_ie is 1.
- R10: A one-cycle pulse on rd_stb clears rx_ready. rx_data is not changed.
- R11: If a frame that would be delivered completes while rx_ready is still 1, overrun_err is set and the new frame is discarded. Reception then stops until rx_en is cleared and set again.
- R12: A change to addr_det_en during a frame applies from the next frame. The frame in progress is judged with the setting that was in force when its start bit was confirmed.
- R13: A low pulse on rx_in shorter than half a bit is not taken as a start bit and produces no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| baud_tick | input | 1 | Oversampling tick, OVS ticks per bit |
| rx_en | input | 1 | Continuous receive enable; low clears error flags |
| nine_bit_en | input | 1 | Nine data bits per frame |
| addr_det_en | input | 1 | Accept only frames with ninth bit 1 (nine-bit mode only) |
| rx_ie | input | 1 | Receive interrupt enable |
| rd_stb | input | 1 | Holding register read strobe |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Received ninth bit |
| rx_ready | output | 1 | Holding register full |
| rx_irq | output | 1 | Receive interrupt |
| frame_err | output | 1 | Stop bit was low on the last delivered frame |
| overrun_err | output | 1 | A deliverable frame was lost to a full register |

## Verification
Assertions check on every cycle that:
- a dropped data frame leaves the holding register and the ready flag untouched;
- overrun sets its flag without overwriting the data;
- a low enable clears both error flags and returns the framer to idle;
- a read clears the ready flag;
- a start pulse that is high at its midpoint is rejected.

Only the bench's scenarios can show:
- bit order and ninth-bit placement on real serial waveforms;
- address filtering being ignored in eight-bit mode;
- reception halting after an overrun until the enable is toggled;
- a change to filtering mid-frame taking effect only at the next frame.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = DATA_W + 1;
    localparam int IDX_W   = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;
endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    output logic rx_s,
    output logic fall
);
    typedef struct packed {
        logic m0;
        logic m1;
        logic prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.m0   = rx_in;
        d.m1   = q.m0;
        d.prev = q.m1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{m0: 1'b1, m1: 1'b1, prev: 1'b1};
        else        q <= d;
    end

    assign rx_s = q.m1;
    assign fall = q.prev & ~q.m1;
endmodule

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame
    import mdrop_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               rx_en,
    input  logic               tick,
    input  logic               rx_s,
    input  logic               fall,
    input  logic               nine_en,
    input  logic               addr_en,
    output logic               done,
    output logic [FRAME_W-1:0] bits,
    output logic               ferr,
    output logic               addr_mode
);
    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;

    typedef struct packed {
        rx_state_e          st;
        logic [CW-1:0]      cnt;
        logic [IDX_W-1:0]   idx;
        logic [FRAME_W-1:0] sh;
        logic               nine;
        logic               addr;
        logic               done;
        logic               ferr;
    } fr_t;

    fr_t q, d;
    logic [IDX_W-1:0] last_idx;

    always_comb begin
        d        = q;
        d.done   = 1'b0;
        last_idx = q.nine ? IDX_W'(FRAME_W - 1) : IDX_W'(DATA_W - 1);
        unique case (q.st)
            ST_IDLE: begin
                if (fall) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.cnt == CW'(HALF - 1)) begin
                        if (!rx_s) begin
                            d.st   = ST_DATA;
                            d.cnt  = '0;
                            d.idx  = '0;
                            d.sh   = '0;
                            d.nine = nine_en;
                            d.addr = addr_en & nine_en;
                        end else begin
                            d.st = ST_IDLE;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.cnt       = '0;
                        d.sh[q.idx] = rx_s;
                        if (q.idx == last_idx) d.st = ST_STOP;
                        else                   d.idx = q.idx + 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.done = 1'b1;
                        d.ferr = ~rx_s;
                        d.st   = ST_IDLE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
        if (!run) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign done      = q.done;
    assign bits      = q.sh;
    assign ferr      = q.ferr;
    assign addr_mode = q.addr;

    p_idle_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (q.st == ST_IDLE));

    p_glitch_reject_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (run && q.st == ST_START && tick && q.cnt == CW'(HALF - 1) && rx_s)
        |=> (q.st == ST_IDLE) && !q.done);
endmodule

// File: rtl/mdrop_rx_buffer.sv
module mdrop_rx_buffer
    import mdrop_rx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_en,
    input  logic               rd_stb,
    input  logic               done,
    input  logic [FRAME_W-1:0] bits,
    input  logic               ferr_in,
    input  logic               addr_mode,
    output logic [DATA_W-1:0]  data,
    output logic               bit9,
    output logic               ready,
    output logic               ferr,
    output logic               oerr
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit9;
        logic              ready;
        logic              ferr;
        logic              oerr;
    } buf_t;

    buf_t q, d;
    logic keep;

    always_comb begin
        d    = q;
        keep = ~(addr_mode & ~bits[FRAME_W-1]);
        if (rd_stb) d.ready = 1'b0;
        if (done && keep) begin
            if (q.ready && !rd_stb) begin
                d.oerr = 1'b1;
            end else begin
                d.data  = bits[DATA_W-1:0];
                d.bit9  = bits[FRAME_W-1];
                d.ready = 1'b1;
                d.ferr  = ferr_in;
            end
        end
        if (!rx_en) begin
            d.oerr = 1'b0;
            d.ferr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data  = q.data;
    assign bit9  = q.bit9;
    assign ready = q.ready;
    assign ferr  = q.ferr;
    assign oerr  = q.oerr;

    p_drop_keeps_buffer_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && addr_mode && !bits[FRAME_W-1])
        |=> $stable(q.data) && $stable(q.bit9) && !$rose(q.ready));

    p_overrun_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en && done && keep && q.ready && !rd_stb)
        |=> q.oerr && $stable(q.data));

    p_disable_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !q.oerr && !q.ferr);

    p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done) |=> !q.ready);
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
    import mdrop_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_in,
    input  logic              baud_tick,
    input  logic              rx_en,
    input  logic              nine_bit_en,
    input  logic              addr_det_en,
    input  logic              rx_ie,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_bit9,
    output logic              rx_ready,
    output logic              rx_irq,
    output logic              frame_err,
    output logic              overrun_err
);
    logic               rx_s, fall, run, done, f_ferr, f_addr;
    logic [FRAME_W-1:0] f_bits;

    assign run = rx_en & ~overrun_err;

    mdrop_rx_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_in (rx_in),
        .rx_s  (rx_s),
        .fall  (fall)
    );

    mdrop_rx_frame #(.OVS(OVS)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .rx_en     (rx_en),
        .tick      (baud_tick),
        .rx_s      (rx_s),
        .fall      (fall),
        .nine_en   (nine_bit_en),
        .addr_en   (addr_det_en),
        .done      (done),
        .bits      (f_bits),
        .ferr      (f_ferr),
        .addr_mode (f_addr)
    );

    mdrop_rx_buffer u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_en     (rx_en),
        .rd_stb    (rd_stb),
        .done      (done),
        .bits      (f_bits),
        .ferr_in   (f_ferr),
        .addr_mode (f_addr),
        .data      (rx_data),
        .bit9      (rx_bit9),
        .ready     (rx_ready),
        .ferr      (frame_err),
        .oerr      (overrun_err)
    );

    assign rx_irq = rx_ready & rx_ie;
endmodule

// File: tb/mdrop_uart_rx_tb.sv
module mdrop_uart_rx_tb;
    localparam int OVS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_in = 1'b1;
    logic       baud_tick = 1'b1;
    logic       rx_en = 1'b0, nine_bit_en = 1'b0, addr_det_en = 1'b0;
    logic       rx_ie = 1'b0, rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_ready, rx_irq, frame_err, overrun_err;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    logic [7:0] last_data = 8'h00;
    logic       last_bit9 = 1'b0;

    always #10 clk = ~clk;

    mdrop_uart_rx #(.OVS(OVS)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_tick(baud_tick),
        .rx_en(rx_en), .nine_bit_en(nine_bit_en), .addr_det_en(addr_det_en),
        .rx_ie(rx_ie), .rd_stb(rd_stb), .rx_data(rx_data), .rx_bit9(rx_bit9),
        .rx_ready(rx_ready), .rx_irq(rx_irq), .frame_err(frame_err),
        .overrun_err(overrun_err)
    );

    typedef struct packed {
        logic       nine;
        logic       addr;
        logic [8:0] bits;
        logic       deliver;
    } vec_t;

    localparam vec_t VEC [0:5] = '{
        '{1'b0, 1'b0, 9'h0A5, 1'b1},   // R2 eight-bit
        '{1'b0, 1'b1, 9'h03C, 1'b1},   // R5 filter ignored in eight-bit
        '{1'b1, 1'b0, 9'h15A, 1'b1},   // R3 R6 ninth bit 1
        '{1'b1, 1'b0, 9'h0C3, 1'b1},   // R6 ninth bit 0 still delivered
        '{1'b1, 1'b1, 9'h17E, 1'b1},   // R4 address frame
        '{1'b1, 1'b1, 9'h011, 1'b0}    // R4 data frame dropped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] bits, input int nbits, input logic stop,
                        input bit clr_addr_mid);
        rx_in = 1'b0;
        hold(OVS);
        for (int i = 0; i < nbits; i++) begin
            if (clr_addr_mid && i == 4) addr_det_en = 1'b0;
            rx_in = bits[i];
            hold(OVS);
        end
        rx_in = stop;
        hold(OVS);
        rx_in = 1'b1;
        hold(4);
    endtask

    task automatic read_buf();
        rd_stb = 1'b1;
        hold(1);
        rd_stb = 1'b0;
        hold(1);
    endtask

    initial begin
        hold(3);
        check("R1 ready", rx_ready, 0);
        check("R1 irq", rx_irq, 0);
        check("R1 ferr", frame_err, 0);
        check("R1 oerr", overrun_err, 0);
        check("R1 data", rx_data, 0);
        check("R1 bit9", rx_bit9, 0);
        rst_n = 1'b1;
        hold(2);
        rx_en = 1'b1;

        for (int i = 0; i < 6; i++) begin
            nine_bit_en = VEC[i].nine;
            addr_det_en = VEC[i].addr;
            rx_ie = i[0];
            hold(2);
            send(VEC[i].bits, VEC[i].nine ? 9 : 8, 1'b1, 1'b0);
            check("R2/R4 ready", rx_ready, VEC[i].deliver);
            check("R9 irq", rx_irq, VEC[i].deliver & i[0]);
            if (VEC[i].deliver) begin
                last_data = VEC[i].bits[7:0];
                last_bit9 = VEC[i].nine & VEC[i].bits[8];
            end
            check("R3/R6 data", rx_data, last_data);
            check("R3 bit9", rx_bit9, last_bit9);
            if (rx_ready) begin
                read_buf();
                check("R10 ready clear", rx_ready, 0);
                check("R10 data kept", rx_data, last_data);
            end
        end

        // R12: filter cleared mid-frame still drops this data frame
        nine_bit_en = 1'b1;
        addr_det_en = 1'b1;
        hold(2);
        send(9'h099, 9, 1'b1, 1'b1);
        check("R12 dropped", rx_ready, 0);
        check("R12 data kept", rx_data, last_data);
        send(9'h098, 9, 1'b1, 1'b0);
        check("R12 next delivered", rx_ready, 1);
        check("R12 data", rx_data, 8'h98);
        check("R12 bit9", rx_bit9, 0);
        read_buf();

        // R13 glitch
        nine_bit_en = 1'b0;
        rx_in = 1'b0;
        hold(4);
        rx_in = 1'b1;
        hold(3 * OVS);
        check("R13 no frame", rx_ready, 0);
        send(9'h0E7, 8, 1'b1, 1'b0);
        check("R13 later frame", rx_data, 8'hE7);
        read_buf();

        // R7 disabled
        rx_en = 1'b0;
        hold(2);
        send(9'h055, 8, 1'b1, 1'b0);
        check("R7 no rx", rx_ready, 0);
        check("R7 data", rx_data, 8'hE7);
        rx_en = 1'b1;
        hold(2);

        // R8 framing error
        send(9'h066, 8, 1'b0, 1'b0);
        check("R8 ferr", frame_err, 1);
        check("R8 data", rx_data, 8'h66);
        read_buf();
        rx_en = 1'b0;
        hold(1);
        check("R7 ferr cleared", frame_err, 0);
        rx_en = 1'b1;
        hold(2);

        // R11 overrun
        send(9'h011, 8, 1'b1, 1'b0);
        send(9'h022, 8, 1'b1, 1'b0);
        check("R11 oerr", overrun_err, 1);
        check("R11 data kept", rx_data, 8'h11);
        send(9'h033, 8, 1'b1, 1'b0);
        check("R11 halted", rx_data, 8'h11);
        rx_en = 1'b0;
        hold(1);
        check("R7 oerr cleared", overrun_err, 0);
        rx_en = 1'b1;
        read_buf();
        check("R11 ready clear", rx_ready, 0);
        send(9'h044, 8, 1'b1, 1'b0);
        check("R11 resumed", rx_data, 8'h44);
        check("R11 resumed ready", rx_ready, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule